// File: doc/BRIEF.md
# Texture-Mapper Control Register Bank

This block is the software-facing front of a texture-mapping accelerator. A processor programs a mapping job through a bank of nineteen 32-bit registers reached by word-aligned byte addresses: the mesh extent, brightness and alpha levels, a chroma-key colour, the vertex table base, the source texture and destination framebuffer bases with their resolutions and masks, the destination offsets, and the size of one destination mesh square. Every register value is presented to the rendering datapath on a flat configuration bus.

Bit 0 of the control word serves as both the start command and the busy indicator. Setting it while idle sends a one-cycle start pulse to the datapath and holds busy until the datapath returns a done strobe. At that point busy drops and a one-cycle interrupt is raised. Bit 1 of the control word enables chroma keying. After each accepted write, the block re-checks the programmed configuration for out-of-range levels and misaligned base addresses. It holds the result on a sticky error output until the next write.

Top module: `tmap_ctrl_bank`

## Requirements
- R1: After reset, every register reads as zero, and `cfg_words`, `job_start`, `irq`, `chroma_en` and `cfg_error` are all zero.
- R2: The register index is the byte address shifted right by 2. Index 0 is control, 3 is brightness (0x0C), 5 is vertex base (0x14), 6 is texture base (0x18), 15 is destination vertical offset (0x3C) and 18 is alpha (0x48). Indices 1..18 read back the last value written to them, one cycle after the read strobe.
- R3: A write is accepted only when all four byte enables are set and address bits [1:0] are zero. Any other write changes nothing.
- R4: Reads of indices 19 and above return zero. Writes to those indices change no register.
- R5: When the block is idle, a control write with bit 0 set produces exactly one cycle of `job_start` in the cycle after the write. Control bit 0 then reads as 1.
- R6: A `job_done` strobe while busy clears control bit 0 and raises `irq` for exactly one cycle, both in the cycle after the strobe. A `job_done` strobe while idle raises no `irq`.
- R7: While busy, control writes are ignored. They issue no `job_start` and leave control bits unchanged.
- R8: `chroma_en` follows control bit 1.
- R9: `cfg_error` is set when brightness or alpha exceeds 63. It is re-evaluated one cycle after every accepted write to a mapped register and holds its value otherwise.
- R10: `cfg_error` is also set when vertex base bits [2:0] are nonzero, or when texture base bit 0 is set.
- R11: `cfg_words[32*i +: 32]` carries register i. For index 0, bit 0 is the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| job_start | output | 1 | One-cycle launch pulse to the datapath |
| job_done | input | 1 | Completion strobe from the datapath |
| irq | output | 1 | One-cycle completion interrupt |
| chroma_en | output | 1 | Chroma keying enable |
| cfg_error | output | 1 | Sticky illegal-configuration flag |
| cfg_words | output | 19*32 | All register contents, index i at bits 32*i upward |

## Verification
The assertions assume that `job_done` is a single-cycle strobe returned by the datapath only after it has seen `job_start`, and that bus strobes are stable around the clock edge. The stimulus drives all inputs on the falling edge and pulses `job_done` for one cycle. It also issues one idle-time `job_done` on purpose, to show that no interrupt follows. The assertions that tie `irq` to a prior busy state hold even for that stray strobe.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
  localparam int REG_W     = 32;
  localparam int N_REGS    = 19;
  localparam int LEVEL_MAX = 63;
  localparam int VTX_LSB_N = 3;
  localparam int TEX_LSB_N = 1;
  localparam int BE_W      = REG_W / 8;

  typedef enum int {
    IX_CTRL = 0, IX_MESH_H, IX_MESH_V, IX_BRIGHT, IX_CKEY, IX_VTX, IX_TEX,
    IX_TEX_HR, IX_TEX_VR, IX_TEX_HM, IX_TEX_VM, IX_DST, IX_DST_HR, IX_DST_VR,
    IX_DST_HO, IX_DST_VO, IX_SQ_W, IX_SQ_H, IX_ALPHA
  } reg_ix_e;

  localparam int CTRL_GO_BIT = 0;
  localparam int CTRL_CK_BIT = 1;

  function automatic logic cfg_bad(input logic [REG_W-1:0] bright,
                                   input logic [REG_W-1:0] alpha,
                                   input logic [VTX_LSB_N-1:0] vtx_lo,
                                   input logic [TEX_LSB_N-1:0] tex_lo);
    return (bright > REG_W'(LEVEL_MAX)) || (alpha > REG_W'(LEVEL_MAX)) ||
           (|vtx_lo) || (|tex_lo);
  endfunction
endpackage

// File: rtl/tmap_regfile.sv
module tmap_regfile
  import tmap_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_acc,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [REG_W-1:0]        wdata,
  input  logic                    busy,
  output logic [REG_W-1:0]        rdata,
  output logic [N_REGS*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] regs_q [N_REGS];
  logic [REG_W-1:0] view   [N_REGS];
  logic             mapped;

  assign mapped = int'(idx) < N_REGS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
    end else if (wr_acc && mapped && (int'(idx) != IX_CTRL || !busy)) begin
      regs_q[idx] <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_view
      if (g == IX_CTRL) begin : g_ctrl
        assign view[g] = {regs_q[g][REG_W-1:1], busy};
      end else begin : g_plain
        assign view[g] = regs_q[g];
      end
      assign regs_flat[g*REG_W +: REG_W] = view[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= mapped ? view[idx] : '0;
  end
endmodule

// File: rtl/tmap_job_ctl.sv
module tmap_job_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_req,
  input  logic done,
  output logic busy,
  output logic job_start,
  output logic irq
);
  logic launch;
  assign launch = launch_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      job_start <= 1'b0;
      irq       <= 1'b0;
    end else begin
      job_start <= launch;
      irq       <= busy && done;
      if (busy && done) busy <= 1'b0;
      else if (launch)  busy <= 1'b1;
    end
  end
endmodule

// File: rtl/tmap_cfg_check.sv
module tmap_cfg_check
  import tmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_evt,
  input  logic [REG_W-1:0]     bright,
  input  logic [REG_W-1:0]     alpha,
  input  logic [VTX_LSB_N-1:0] vtx_lo,
  input  logic [TEX_LSB_N-1:0] tex_lo,
  output logic                 err
);
  logic wr_evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_evt_q <= 1'b0;
      err      <= 1'b0;
    end else begin
      wr_evt_q <= wr_evt;
      if (wr_evt_q) err <= cfg_bad(bright, alpha, vtx_lo, tex_lo);
    end
  end
endmodule

// File: rtl/tmap_ctrl_bank.sv
module tmap_ctrl_bank
  import tmap_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [3:0]                     bus_be,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           job_start,
  input  logic                           job_done,
  output logic                           irq,
  output logic                           chroma_en,
  output logic                           cfg_error,
  output logic [tmap_pkg::N_REGS*32-1:0] cfg_words
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_acc;
  logic             wr_mapped;
  logic             ctrl_go_req;
  logic             busy;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign wr_acc      = bus_wr && (bus_be == {BE_W{1'b1}}) && (bus_addr[1:0] == 2'b00);
  assign wr_mapped   = wr_acc && (int'(idx) < N_REGS);
  assign ctrl_go_req = wr_acc && (int'(idx) == IX_CTRL) && bus_wdata[CTRL_GO_BIT];

  tmap_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_en(bus_rd), .idx(idx),
    .wdata(bus_wdata), .busy(busy), .rdata(bus_rdata), .regs_flat(cfg_words)
  );

  tmap_job_ctl u_job (
    .clk(clk), .rst_n(rst_n), .launch_req(ctrl_go_req), .done(job_done),
    .busy(busy), .job_start(job_start), .irq(irq)
  );

  tmap_cfg_check u_chk (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_mapped),
    .bright(cfg_words[IX_BRIGHT*REG_W +: REG_W]),
    .alpha(cfg_words[IX_ALPHA*REG_W +: REG_W]),
    .vtx_lo(cfg_words[IX_VTX*REG_W +: VTX_LSB_N]),
    .tex_lo(cfg_words[IX_TEX*REG_W +: TEX_LSB_N]),
    .err(cfg_error)
  );

  assign chroma_en = cfg_words[IX_CTRL*REG_W + CTRL_CK_BIT];
endmodule

// File: rtl/tmap_ctrl_bank_sva.sv
module tmap_ctrl_bank_sva (
  input logic clk,
  input logic rst_n,
  input logic job_start,
  input logic job_done,
  input logic irq,
  input logic busy
);
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);
  a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> busy);
  a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> !$past(busy));
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(busy) && $past(job_done) && !busy));
  a_r6_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && job_done) |=> (!busy && irq));
endmodule

bind tmap_ctrl_bank tmap_ctrl_bank_sva u_sva (
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_done(job_done),
  .irq(irq), .busy(busy)
);

// File: tb/tmap_ctrl_bank_tb.sv
module tmap_ctrl_bank_tb_top;
  localparam int AW = 7;
  localparam int NR = 19;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [3:0]     bus_be = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           job_start, job_done = 1'b0, irq, chroma_en, cfg_error;
  logic [NR*32-1:0] cfg_words;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tmap_ctrl_bank #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .job_start(job_start), .job_done(job_done),
    .irq(irq), .chroma_en(chroma_en), .cfg_error(cfg_error),
    .cfg_words(cfg_words)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr_err(input logic [AW-1:0] a, input logic [31:0] d, input logic exp, input string req);
    wr(a, d);
    @(negedge clk);
    chk(req, {31'b0, cfg_error}, {31'b0, exp});
  endtask

  task automatic t_reset();
    chk("R1 cfg_words", {31'b0, |cfg_words}, 32'd0);
    chk("R1 outputs", {28'b0, job_start, irq, chroma_en, cfg_error}, 32'd0);
    rd_chk("R1 ctrl", 7'h00, 32'd0);
    rd_chk("R1 alpha", 7'h48, 32'd0);
  endtask

  task automatic t_rw();
    wr(7'h0C, 32'h2A); wr(7'h48, 32'h3F); wr(7'h04, 32'h1234_5678); wr(7'h3C, 32'hDEAD_BEEF);
    rd_chk("R2 bright", 7'h0C, 32'h2A);
    rd_chk("R2 alpha", 7'h48, 32'h3F);
    rd_chk("R2 mesh_h", 7'h04, 32'h1234_5678);
    rd_chk("R2 dst_vo", 7'h3C, 32'hDEAD_BEEF);
    chk("R11 slice mesh_h", cfg_words[1*32 +: 32], 32'h1234_5678);
    chk("R11 slice dst_vo", cfg_words[15*32 +: 32], 32'hDEAD_BEEF);
  endtask

  task automatic t_partial();
    wr(7'h0C, 32'h11, 4'h3);
    rd_chk("R3 partial be", 7'h0C, 32'h2A);
    wr(7'h0D, 32'h22);
    rd_chk("R3 misaligned", 7'h0C, 32'h2A);
  endtask

  task automatic t_unmapped();
    wr(7'h4C, 32'hFFFF_FFFF);
    rd_chk("R4 read 0x4C", 7'h4C, 32'd0);
    rd_chk("R4 read 0x7C", 7'h7C, 32'd0);
    rd_chk("R4 bright kept", 7'h0C, 32'h2A);
    chk("R4 regs unchanged", {31'b0, cfg_words[18*32 +: 32] == 32'h3F}, 32'd1);
  endtask

  task automatic t_err();
    wr_err(7'h0C, 32'd64, 1'b1, "R9 bright 64");
    repeat (3) @(negedge clk);
    chk("R9 sticky", {31'b0, cfg_error}, 32'd1);
    wr_err(7'h0C, 32'd63, 1'b0, "R9 bright 63");
    wr_err(7'h48, 32'd64, 1'b1, "R9 alpha 64");
    wr_err(7'h10, 32'd0, 1'b1, "R9 re-eval other reg");
    wr_err(7'h48, 32'd0, 1'b0, "R9 alpha 0");
    wr_err(7'h14, 32'h1004, 1'b1, "R10 vtx misaligned");
    wr_err(7'h14, 32'h1008, 1'b0, "R10 vtx aligned");
    wr_err(7'h18, 32'h2001, 1'b1, "R10 tex odd");
    wr_err(7'h18, 32'h2002, 1'b0, "R10 tex even");
  endtask

  task automatic t_job();
    wr(7'h00, 32'h3);
    chk("R5 start pulse", {31'b0, job_start}, 32'd1);
    @(negedge clk);
    chk("R5 start one cycle", {31'b0, job_start}, 32'd0);
    chk("R8 chroma on", {31'b0, chroma_en}, 32'd1);
    chk("R11 busy bit", {31'b0, cfg_words[0]}, 32'd1);
    rd_chk("R5 ctrl busy", 7'h00, 32'h3);
    wr(7'h00, 32'h1);
    chk("R7 no restart", {31'b0, job_start}, 32'd0);
    wr(7'h00, 32'h0);
    rd_chk("R7 ctrl kept", 7'h00, 32'h3);
    job_done = 1'b1; @(posedge clk); @(negedge clk); job_done = 1'b0;
    chk("R6 irq pulse", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R6 irq one cycle", {31'b0, irq}, 32'd0);
    rd_chk("R6 busy cleared", 7'h00, 32'h2);
    job_done = 1'b1; @(posedge clk); @(negedge clk); job_done = 1'b0;
    chk("R6 idle done no irq", {31'b0, irq}, 32'd0);
    wr(7'h00, 32'h0);
    chk("R8 chroma off", {31'b0, chroma_en}, 32'd0);
    chk("R5 idle no start", {31'b0, job_start}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_partial();
    t_unmapped();
    t_err();
    t_job();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule